// File: doc/BRIEF.md
# MI Coherence Line Controller

This block runs the coherence protocol for one line of a private cache that keeps its lines coherent with a directory. Only two stable states exist: the line is either owned and writable (M) or absent (I). A miss of any kind, read or write, therefore asks the directory for exclusive ownership. Transient states cover outstanding misses and outstanding writebacks. While a writeback is pending, a one-entry writeback buffer holds the evicted data, so that a forwarded ownership request arriving in that window can still be answered after the line has left the cache.

Four input ports feed the controller: processor operations, replacement demands from the tag logic, directory forwards and fill data. It accepts at most one event per cycle. The outputs are the following:
- requests to the directory, either an ownership request or a writeback carrying data;
- data responses to other caches;
- completion pulses to the processor, flagged as hit or external fill;
- an optional eviction notice.

Outgoing directory requests and data responses leave after fixed latencies set by parameters. Events that the current state cannot take are either stalled, with the port's ready held low, or consumed while a sticky error flag is raised.

Top module: `mi_line_ctrl`

## Requirements
- R1: After reset the line is absent (I). No request, data response, completion, eviction notice or error is asserted.
- R2: In I, a processor operation is accepted. The operation codes are 0 load, 1 fetch, 2 store and 3 atomic. The line then moves to a pending-miss state, and an ownership request (req_kind_o = 0) appears exactly REQ_LAT cycles after the accepting cycle.
- R3: When fill data is accepted in a pending-miss state, a completion pulse with done_ext_o = 1 follows one cycle later and the line becomes M. The pulse reports the operation class in done_store_o (store or atomic = 1). It returns the new line value, which is the fill data for a read miss or the processor's write data for a write miss.
- R4: In M, every operation completes one cycle later with done_ext_o = 0 and sends nothing to the directory. A load or fetch returns the line value, and a store or atomic replaces the line with its write data and returns it.
- R5: In M, a forwarded ownership request (kind 0) sends the line data to the requestor exactly RSP_LAT cycles after the accepting cycle. It also raises an eviction notice and moves the line to I.
- R6: In M, a replacement or an invalidate (kind 1) copies the line into the writeback buffer and sends a writeback (req_kind_o = 1) with the line data after REQ_LAT cycles. It also raises an eviction notice and enters writeback-pending (MI).
- R7: In MI, the following forward kinds are handled:
  - a writeback acknowledgement (kind 2) goes to I;
  - a writeback rejection (kind 3) goes to MII;
  - a forwarded ownership request is answered from the writeback buffer and goes to II;
  - an invalidate is consumed without a state change.
- R8: In MII, a forwarded ownership request is answered from the writeback buffer and the line goes to I. In II, a writeback rejection returns the line to I.
- R9: In any transient state, processor operations and replacements are not accepted. In the pending-miss states, forwarded ownership requests and invalidates are not accepted either.
- R10: The eviction notice is produced only while evict_en_i is high.
- R11: An event that the current state does not expect is consumed, leaves the state unchanged and sets err_o. Once set, err_o stays high until reset.
- R12: At most one event is accepted per cycle, in this priority order: fill, forward, replacement, processor operation. A lower-priority input that is not accepted sees its ready held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evict_en_i | input | 1 | Enables eviction notices |
| cpu_valid_i | input | 1 | Processor operation present |
| cpu_op_i | input | 2 | 0 load, 1 fetch, 2 store, 3 atomic |
| cpu_wdata_i | input | DATA_W | Store/atomic write data |
| cpu_ready_o | output | 1 | Processor operation accepted this cycle |
| repl_valid_i | input | 1 | Replacement demand for the line |
| repl_ready_o | output | 1 | Replacement accepted |
| fwd_valid_i | input | 1 | Directory forward present |
| fwd_kind_i | input | 2 | 0 take ownership, 1 invalidate, 2 writeback ack, 3 writeback reject |
| fwd_src_i | input | ID_W | Requestor of a forwarded ownership request |
| fwd_ready_o | output | 1 | Forward accepted |
| fill_valid_i | input | 1 | Fill data present |
| fill_data_i | input | DATA_W | Fill data |
| fill_ready_o | output | 1 | Fill accepted |
| req_valid_o | output | 1 | Request to directory |
| req_kind_o | output | 1 | 0 ownership request, 1 writeback |
| req_data_o | output | DATA_W | Writeback data (zero for ownership request) |
| dat_valid_o | output | 1 | Data response to another cache |
| dat_dst_o | output | ID_W | Destination of the data response |
| dat_data_o | output | DATA_W | Response data |
| done_o | output | 1 | Completion pulse to processor |
| done_store_o | output | 1 | Completion was a store/atomic |
| done_ext_o | output | 1 | Completion came from a fill |
| done_data_o | output | DATA_W | Line value after the operation |
| evict_o | output | 1 | Eviction notice |
| err_o | output | 1 | Sticky unexpected-event flag |

## Verification
All four operation codes are swept through the miss, fill, hit and forwarded-ownership cycle. This separates read-class from write-class decode, and it shows whether a write miss returns the processor data or the fill data. Both eviction triggers are run with the notice enabled and disabled. Every exit from the writeback-pending states is walked, including the rejection race, so that data served from the buffer can be told apart from stale line data. Simultaneous inputs show the arbitration order. Stalled inputs and an unexpected directory message show, at the ports, which events are refused, which are dropped and which only set the flag.

// File: rtl/mi_pkg.sv
package mi_pkg;
  typedef enum logic [2:0] {ST_I, ST_M, ST_IS, ST_IM, ST_MI, ST_MII, ST_II} state_e;

  typedef enum logic [3:0] {
    EV_NONE, EV_READ, EV_WRITE, EV_REPL, EV_TAKE, EV_INV, EV_WB_OK, EV_WB_REJ, EV_FILL
  } event_e;

  localparam logic [1:0] OP_LOAD   = 2'd0;
  localparam logic [1:0] OP_FETCH  = 2'd1;
  localparam logic [1:0] OP_STORE  = 2'd2;
  localparam logic [1:0] OP_ATOMIC = 2'd3;

  localparam logic [1:0] FWD_TAKE   = 2'd0;
  localparam logic [1:0] FWD_INV    = 2'd1;
  localparam logic [1:0] FWD_WB_OK  = 2'd2;
  localparam logic [1:0] FWD_WB_REJ = 2'd3;

  localparam logic REQ_OWN = 1'b0;
  localparam logic REQ_WB  = 1'b1;

  typedef struct packed {
    state_e nxt;
    logic   stall;
    logic   err;
    logic   hit;
    logic   fill;
    logic   own_req;
    logic   wb_req;
    logic   send_dat;
    logic   dat_from_wb;
    logic   evict;
    logic   wb_load;
  } action_t;
endpackage

// File: rtl/mi_event_sel.sv
module mi_event_sel
  import mi_pkg::*;
(
  input  logic       cpu_valid_i,
  input  logic [1:0] cpu_op_i,
  input  logic       repl_valid_i,
  input  logic       fwd_valid_i,
  input  logic [1:0] fwd_kind_i,
  input  logic       fill_valid_i,
  output event_e     ev_o
);
  always_comb begin
    ev_o = EV_NONE;
    if (fill_valid_i) begin
      ev_o = EV_FILL;
    end else if (fwd_valid_i) begin
      unique case (fwd_kind_i)
        FWD_TAKE:  ev_o = EV_TAKE;
        FWD_INV:   ev_o = EV_INV;
        FWD_WB_OK: ev_o = EV_WB_OK;
        default:   ev_o = EV_WB_REJ;
      endcase
    end else if (repl_valid_i) begin
      ev_o = EV_REPL;
    end else if (cpu_valid_i) begin
      ev_o = (cpu_op_i == OP_STORE || cpu_op_i == OP_ATOMIC) ? EV_WRITE : EV_READ;
    end
  end
endmodule

// File: rtl/mi_transition.sv
module mi_transition
  import mi_pkg::*;
(
  input  state_e  state_i,
  input  event_e  ev_i,
  output action_t act_o
);
  always_comb begin
    act_o     = '0;
    act_o.nxt = state_i;
    if (ev_i inside {EV_READ, EV_WRITE, EV_REPL} && !(state_i inside {ST_I, ST_M})) begin
      act_o.stall = 1'b1;
    end else if (ev_i inside {EV_TAKE, EV_INV} && state_i inside {ST_IS, ST_IM}) begin
      act_o.stall = 1'b1;
    end else if (ev_i != EV_NONE) begin
      case (state_i)
        ST_I: case (ev_i)
          EV_READ:         begin act_o.nxt = ST_IS; act_o.own_req = 1'b1; end
          EV_WRITE:        begin act_o.nxt = ST_IM; act_o.own_req = 1'b1; end
          EV_REPL, EV_INV: ;
          default:         act_o.err = 1'b1;
        endcase
        ST_M: case (ev_i)
          EV_READ, EV_WRITE: act_o.hit = 1'b1;
          EV_TAKE: begin
            act_o.send_dat = 1'b1;
            act_o.evict    = 1'b1;
            act_o.nxt      = ST_I;
          end
          EV_REPL, EV_INV: begin
            act_o.wb_load = 1'b1;
            act_o.wb_req  = 1'b1;
            act_o.evict   = 1'b1;
            act_o.nxt     = ST_MI;
          end
          default: act_o.err = 1'b1;
        endcase
        ST_IS, ST_IM: begin
          if (ev_i == EV_FILL) begin
            act_o.fill = 1'b1;
            act_o.nxt  = ST_M;
          end else begin
            act_o.err = 1'b1;
          end
        end
        ST_MI: case (ev_i)
          EV_WB_OK:  act_o.nxt = ST_I;
          EV_WB_REJ: act_o.nxt = ST_MII;
          EV_TAKE: begin
            act_o.send_dat    = 1'b1;
            act_o.dat_from_wb = 1'b1;
            act_o.nxt         = ST_II;
          end
          EV_INV:  ;
          default: act_o.err = 1'b1;
        endcase
        ST_MII: begin
          if (ev_i == EV_TAKE) begin
            act_o.send_dat    = 1'b1;
            act_o.dat_from_wb = 1'b1;
            act_o.nxt         = ST_I;
          end else begin
            act_o.err = 1'b1;
          end
        end
        ST_II: begin
          if (ev_i == EV_WB_REJ) act_o.nxt = ST_I;
          else                   act_o.err = 1'b1;
        end
        default: act_o.nxt = ST_I;
      endcase
    end
  end
endmodule

// File: rtl/mi_msg_delay.sv
module mi_msg_delay #(
  parameter int LAT = 2,
  parameter int W   = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  generate
    if (LAT == 0) begin : g_pass
      assign valid_o = valid_i;
      assign data_o  = data_i;
    end else begin : g_pipe
      logic [LAT-1:0] vld_q;
      logic [W-1:0]   pay_q [LAT];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q <= '0;
        end else begin
          vld_q[0] <= valid_i;
          for (int i = 1; i < LAT; i++) vld_q[i] <= vld_q[i-1];
        end
      end

      always_ff @(posedge clk_i) begin
        pay_q[0] <= data_i;
        for (int i = 1; i < LAT; i++) pay_q[i] <= pay_q[i-1];
      end

      assign valid_o = vld_q[LAT-1];
      assign data_o  = pay_q[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/mi_line_ctrl.sv
module mi_line_ctrl
  import mi_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ID_W    = 3,
  parameter int REQ_LAT = 2,
  parameter int RSP_LAT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evict_en_i,
  input  logic              cpu_valid_i,
  input  logic [1:0]        cpu_op_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  input  logic              repl_valid_i,
  output logic              repl_ready_o,
  input  logic              fwd_valid_i,
  input  logic [1:0]        fwd_kind_i,
  input  logic [ID_W-1:0]   fwd_src_i,
  output logic              fwd_ready_o,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              fill_ready_o,
  output logic              req_valid_o,
  output logic              req_kind_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic              dat_valid_o,
  output logic [ID_W-1:0]   dat_dst_o,
  output logic [DATA_W-1:0] dat_data_o,
  output logic              done_o,
  output logic              done_store_o,
  output logic              done_ext_o,
  output logic [DATA_W-1:0] done_data_o,
  output logic              evict_o,
  output logic              err_o
);
  localparam int REQ_PW = 1 + DATA_W;
  localparam int DAT_PW = ID_W + DATA_W;

  state_e            state_q;
  event_e            ev;
  action_t           act;
  logic              fire;
  logic [DATA_W-1:0] line_q, wb_q, pend_q, line_d;
  logic              err_q, evict_q;
  logic              done_q, done_store_q, done_ext_q;
  logic [DATA_W-1:0] done_data_q;
  logic [REQ_PW-1:0] req_pay_in, req_pay_out;
  logic [DAT_PW-1:0] dat_pay_in, dat_pay_out;

  mi_event_sel u_sel (
    .cpu_valid_i (cpu_valid_i),
    .cpu_op_i    (cpu_op_i),
    .repl_valid_i(repl_valid_i),
    .fwd_valid_i (fwd_valid_i),
    .fwd_kind_i  (fwd_kind_i),
    .fill_valid_i(fill_valid_i),
    .ev_o        (ev)
  );

  mi_transition u_fsm (
    .state_i(state_q),
    .ev_i   (ev),
    .act_o  (act)
  );

  assign fire         = (ev != EV_NONE) && !act.stall;
  assign cpu_ready_o  = fire && (ev inside {EV_READ, EV_WRITE});
  assign repl_ready_o = fire && (ev == EV_REPL);
  assign fwd_ready_o  = fire && (ev inside {EV_TAKE, EV_INV, EV_WB_OK, EV_WB_REJ});
  assign fill_ready_o = fire && (ev == EV_FILL);

  // write miss: the pending store data overrides the filled line
  always_comb begin
    line_d = line_q;
    if (fire && act.hit && ev == EV_WRITE) line_d = cpu_wdata_i;
    else if (fire && act.fill)             line_d = (state_q == ST_IM) ? pend_q : fill_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_I;
      line_q       <= '0;
      wb_q         <= '0;
      pend_q       <= '0;
      err_q        <= 1'b0;
      evict_q      <= 1'b0;
      done_q       <= 1'b0;
      done_store_q <= 1'b0;
      done_ext_q   <= 1'b0;
      done_data_q  <= '0;
    end else begin
      if (fire) state_q <= act.nxt;
      line_q <= line_d;
      if (fire && act.own_req) pend_q <= cpu_wdata_i;
      if (fire && act.wb_load) wb_q <= line_q;
      err_q        <= err_q | (fire && act.err);
      evict_q      <= fire && act.evict && evict_en_i;
      done_q       <= fire && (act.hit || act.fill);
      done_store_q <= fire && (act.fill ? (state_q == ST_IM) : (act.hit && ev == EV_WRITE));
      done_ext_q   <= fire && act.fill;
      done_data_q  <= line_d;
    end
  end

  assign req_pay_in = {act.wb_req, act.wb_req ? line_q : {DATA_W{1'b0}}};
  assign dat_pay_in = {fwd_src_i, act.dat_from_wb ? wb_q : line_q};

  mi_msg_delay #(.LAT(REQ_LAT), .W(REQ_PW)) u_req_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(fire && (act.own_req || act.wb_req)),
    .data_i (req_pay_in),
    .valid_o(req_valid_o),
    .data_o (req_pay_out)
  );

  mi_msg_delay #(.LAT(RSP_LAT), .W(DAT_PW)) u_dat_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(fire && act.send_dat),
    .data_i (dat_pay_in),
    .valid_o(dat_valid_o),
    .data_o (dat_pay_out)
  );

  assign req_kind_o   = req_pay_out[REQ_PW-1];
  assign req_data_o   = req_pay_out[DATA_W-1:0];
  assign dat_dst_o    = dat_pay_out[DAT_PW-1:DATA_W];
  assign dat_data_o   = dat_pay_out[DATA_W-1:0];
  assign done_o       = done_q;
  assign done_store_o = done_store_q;
  assign done_ext_o   = done_ext_q;
  assign done_data_o  = done_data_q;
  assign evict_o      = evict_q;
  assign err_o        = err_q;
endmodule

// File: rtl/mi_line_ctrl_chk.sv
module mi_line_ctrl_chk
  import mi_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input state_e     state_i,
  input logic       cpu_valid_i,
  input logic       cpu_ready_o,
  input logic       repl_ready_o,
  input logic       fwd_valid_i,
  input logic [1:0] fwd_kind_i,
  input logic       fwd_ready_o,
  input logic       fill_valid_i,
  input logic       fill_ready_o,
  input logic       done_o,
  input logic       done_ext_o,
  input logic       err_o
);
  assert_miss_leaves_i_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_I && cpu_valid_i && cpu_ready_o) |=> (state_i inside {ST_IS, ST_IM}));

  assert_fill_completes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fill_ready_o && state_i inside {ST_IS, ST_IM})
      |=> (done_o && done_ext_o && state_i == ST_M));

  assert_hit_local_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_M && cpu_valid_i && cpu_ready_o) |=> (done_o && !done_ext_o && state_i == ST_M));

  assert_mii_take_exits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_MII && fwd_valid_i && fwd_ready_o && fwd_kind_i == 2'd0) |=> (state_i == ST_I));

  assert_transient_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(state_i inside {ST_I, ST_M})) |-> (!cpu_ready_o && !repl_ready_o));

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_single_event_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cpu_ready_o, repl_ready_o, fwd_ready_o, fill_ready_o}) <= 1);
endmodule

bind mi_line_ctrl mi_line_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_i     (state_q),
  .cpu_valid_i (cpu_valid_i),
  .cpu_ready_o (cpu_ready_o),
  .repl_ready_o(repl_ready_o),
  .fwd_valid_i (fwd_valid_i),
  .fwd_kind_i  (fwd_kind_i),
  .fwd_ready_o (fwd_ready_o),
  .fill_valid_i(fill_valid_i),
  .fill_ready_o(fill_ready_o),
  .done_o      (done_o),
  .done_ext_o  (done_ext_o),
  .err_o       (err_o)
);

// File: tb/sim_mi_line_ctrl.sv
`timescale 1ns/1ps
module sim_mi_line_ctrl;
  localparam int DW = 16;
  localparam int IW = 3;
  localparam int RL = 2;
  localparam int DL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          evict_en_i = 1'b0;
  logic          cpu_valid_i = 1'b0, repl_valid_i = 1'b0, fwd_valid_i = 1'b0, fill_valid_i = 1'b0;
  logic [1:0]    cpu_op_i = '0, fwd_kind_i = '0;
  logic [DW-1:0] cpu_wdata_i = '0, fill_data_i = '0;
  logic [IW-1:0] fwd_src_i = '0;
  logic          cpu_ready_o, repl_ready_o, fwd_ready_o, fill_ready_o;
  logic          req_valid_o, req_kind_o, dat_valid_o;
  logic [DW-1:0] req_data_o, dat_data_o, done_data_o;
  logic [IW-1:0] dat_dst_o;
  logic          done_o, done_store_o, done_ext_o, evict_o, err_o;

  mi_line_ctrl #(.DATA_W(DW), .ID_W(IW), .REQ_LAT(RL), .RSP_LAT(DL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evict_en_i(evict_en_i),
    .cpu_valid_i(cpu_valid_i), .cpu_op_i(cpu_op_i), .cpu_wdata_i(cpu_wdata_i), .cpu_ready_o(cpu_ready_o),
    .repl_valid_i(repl_valid_i), .repl_ready_o(repl_ready_o),
    .fwd_valid_i(fwd_valid_i), .fwd_kind_i(fwd_kind_i), .fwd_src_i(fwd_src_i), .fwd_ready_o(fwd_ready_o),
    .fill_valid_i(fill_valid_i), .fill_data_i(fill_data_i), .fill_ready_o(fill_ready_o),
    .req_valid_o(req_valid_o), .req_kind_o(req_kind_o), .req_data_o(req_data_o),
    .dat_valid_o(dat_valid_o), .dat_dst_o(dat_dst_o), .dat_data_o(dat_data_o),
    .done_o(done_o), .done_store_o(done_store_o), .done_ext_o(done_ext_o), .done_data_o(done_data_o),
    .evict_o(evict_o), .err_o(err_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int req_n = 0, req_c = 0, dat_n = 0, dat_c = 0;
  logic req_k;
  logic [DW-1:0] req_d, dat_d;
  logic [IW-1:0] dat_s;
  always @(negedge clk) begin
    if (req_valid_o) begin req_n++; req_c = cyc; req_k = req_kind_o; req_d = req_data_o; end
    if (dat_valid_o) begin dat_n++; dat_c = cyc; dat_s = dat_dst_o; dat_d = dat_data_o; end
  end

  int n_chk = 0, n_bad = 0;
  bit fin = 1'b0;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  logic acc, d_done, d_ext, d_store, d_evict;
  logic [DW-1:0] d_data;
  int ev_c;

  // kind: 0 cpu, 1 replacement, 2 forward, 3 fill; called at a falling edge
  task automatic ev(int kind, int sub, logic [DW-1:0] dat);
    case (kind)
      0: begin cpu_valid_i = 1; cpu_op_i = 2'(sub); cpu_wdata_i = dat; end
      1: repl_valid_i = 1;
      2: begin fwd_valid_i = 1; fwd_kind_i = 2'(sub); fwd_src_i = dat[IW-1:0]; end
      default: begin fill_valid_i = 1; fill_data_i = dat; end
    endcase
    #1;
    acc  = (kind == 0) ? cpu_ready_o : (kind == 1) ? repl_ready_o :
           (kind == 2) ? fwd_ready_o : fill_ready_o;
    ev_c = cyc;
    @(posedge clk);
    @(negedge clk);
    d_done = done_o; d_ext = done_ext_o; d_store = done_store_o;
    d_data = done_data_o; d_evict = evict_o;
    cpu_valid_i = 0; repl_valid_i = 0; fwd_valid_i = 0; fill_valid_i = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n0;
    logic [DW-1:0] exp_line;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_valid", req_valid_o, 0);
    chk("R1 dat_valid", dat_valid_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 evict", evict_o, 0);
    chk("R1 err", err_o, 0);

    evict_en_i = 1'b1;
    // sweep of all four operation codes through miss, fill, hits, forwarded take
    for (int op = 0; op < 4; op++) begin
      logic [DW-1:0] w, fd, w2;
      w  = DW'(16'hA000 + op);
      fd = DW'(16'h1234 + op * 16'h0101);
      w2 = DW'(16'hC000 + op * 3);
      n0 = req_n;
      ev(0, op, w);
      chk("R2 miss accepted", acc, 1);
      chk("R2 no completion on miss", d_done, 0);
      idle(RL);
      chk("R2 one request", req_n, n0 + 1);
      chk("R2 request latency", req_c, ev_c + RL);
      chk("R2 ownership kind", req_k, 0);
      ev(0, 0, 0);  chk("R9 cpu stalled in miss", acc, 0);
      ev(1, 0, 0);  chk("R9 repl stalled in miss", acc, 0);
      ev(2, 0, 0);  chk("R9 take stalled in miss", acc, 0);
      ev(2, 1, 0);  chk("R9 inv stalled in miss", acc, 0);
      ev(3, 0, fd);
      exp_line = (op >= 2) ? w : fd;
      chk("R3 fill accepted", acc, 1);
      chk("R3 fill done", d_done, 1);
      chk("R3 fill ext", d_ext, 1);
      chk("R3 fill store flag", d_store, (op >= 2) ? 1 : 0);
      chk("R3 fill data", d_data, exp_line);
      n0 = req_n;
      ev(0, 0, 0);
      chk("R4 load hit done", d_done, 1);
      chk("R4 load hit ext", d_ext, 0);
      chk("R4 load hit data", d_data, exp_line);
      ev(0, 2 + (op % 2), w2);
      chk("R4 store hit store flag", d_store, 1);
      chk("R4 store hit data", d_data, w2);
      ev(0, 1, 0);
      chk("R4 fetch sees store", d_data, w2);
      idle(RL + 1);
      chk("R4 no traffic on hits", req_n, n0);
      n0 = dat_n;
      ev(2, 0, DW'(op + 1));
      chk("R5 take accepted", acc, 1);
      chk("R5 eviction notice", d_evict, 1);
      idle(DL);
      chk("R5 one response", dat_n, n0 + 1);
      chk("R5 response latency", dat_c, ev_c + DL);
      chk("R5 response dest", dat_s, op + 1);
      chk("R5 response data", dat_d, w2);
    end

    // replacement with notices disabled, reject race, take from buffer
    evict_en_i = 1'b0;
    ev(0, 0, 0); idle(RL); ev(3, 0, 16'h5A5A);
    n0 = req_n;
    ev(1, 0, 0);
    chk("R6 repl accepted", acc, 1);
    chk("R10 notice suppressed", d_evict, 0);
    idle(RL);
    chk("R6 writeback sent", req_n, n0 + 1);
    chk("R6 writeback latency", req_c, ev_c + RL);
    chk("R6 writeback kind", req_k, 1);
    chk("R6 writeback data", req_d, 16'h5A5A);
    ev(0, 0, 0); chk("R9 cpu stalled in MI", acc, 0);
    ev(2, 1, 0); chk("R7 inv consumed in MI", acc, 1);
    chk("R7 inv no error", err_o, 0);
    ev(2, 3, 0); chk("R7 reject accepted", acc, 1);
    ev(0, 0, 0); chk("R9 cpu stalled in MII", acc, 0);
    n0 = dat_n;
    ev(2, 0, 5); chk("R8 take in MII accepted", acc, 1);
    idle(DL);
    chk("R8 buffer response", dat_n, n0 + 1);
    chk("R8 buffer dest", dat_s, 5);
    chk("R8 buffer data", dat_d, 16'h5A5A);
    n0 = req_n;
    ev(0, 0, 0); chk("R8 back in I", acc, 1);
    idle(RL);
    chk("R8 miss after MII", req_k, 0);
    chk("R8 miss request count", req_n, n0 + 1);
    ev(3, 0, 16'h3C3C);

    // invalidate in M with notices, take while pending, reject in II
    evict_en_i = 1'b1;
    ev(2, 1, 0);
    chk("R6 inv evicts", acc, 1);
    chk("R10 notice enabled", d_evict, 1);
    idle(RL);
    chk("R6 inv writeback kind", req_k, 1);
    chk("R6 inv writeback data", req_d, 16'h3C3C);
    n0 = dat_n;
    ev(2, 0, 6); chk("R7 take in MI accepted", acc, 1);
    idle(DL);
    chk("R7 buffer response", dat_n, n0 + 1);
    chk("R7 buffer data", dat_d, 16'h3C3C);
    chk("R7 buffer dest", dat_s, 6);
    ev(0, 0, 0); chk("R9 cpu stalled in II", acc, 0);
    ev(2, 3, 0); chk("R8 reject in II", acc, 1);
    ev(0, 0, 0); chk("R8 back in I after II", acc, 1);
    idle(RL);
    ev(3, 0, 16'h7777);
    ev(1, 0, 0); idle(RL);
    ev(2, 2, 0); chk("R7 ack in MI", acc, 1);
    ev(0, 0, 0); chk("R7 back in I after ack", acc, 1);
    chk("R7 no error on normal flow", err_o, 0);
    idle(RL);
    ev(3, 0, 16'h0001);

    // arbitration
    cpu_valid_i = 1; cpu_op_i = 0; fwd_valid_i = 1; fwd_kind_i = 0; fwd_src_i = 2;
    #1;
    chk("R12 forward wins", fwd_ready_o, 1);
    chk("R12 cpu held", cpu_ready_o, 0);
    @(posedge clk); @(negedge clk);
    chk("R12 no cpu completion", done_o, 0);
    cpu_valid_i = 0; fwd_valid_i = 0;
    ev(0, 0, 0); idle(RL);
    fill_valid_i = 1; fill_data_i = 16'h2222; fwd_valid_i = 1; fwd_kind_i = 1;
    #1;
    chk("R12 fill wins", fill_ready_o, 1);
    chk("R12 forward held", fwd_ready_o, 0);
    @(posedge clk); @(negedge clk);
    chk("R12 fill completion", done_o, 1);
    fill_valid_i = 0; fwd_valid_i = 0;
    repl_valid_i = 1; cpu_valid_i = 1;
    #1;
    chk("R12 repl wins", repl_ready_o, 1);
    chk("R12 cpu held by repl", cpu_ready_o, 0);
    @(posedge clk); @(negedge clk);
    repl_valid_i = 0; cpu_valid_i = 0;
    idle(RL);
    ev(2, 2, 0);

    // unexpected message
    chk("R11 clean before", err_o, 0);
    ev(2, 2, 0);
    chk("R11 unexpected consumed", acc, 1);
    chk("R11 flag set", err_o, 1);
    n0 = req_n;
    ev(0, 0, 0);
    chk("R11 state unchanged", acc, 1);
    idle(RL);
    chk("R11 still I", req_n, n0 + 1);
    idle(5);
    chk("R11 flag sticky", err_o, 1);

    fin = 1'b1;
    summary();
    $finish;
  end
endmodule